// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns software interrupt requests from a group of CPUs into per-CPU pending state. A CPU issues a request by writing a 32-bit trigger word, which names one of 16 software interrupt IDs and picks the target CPUs. For every pair of ID and target CPU, the block keeps a bitmap of the source CPUs that requested that ID. An ID is pending on a target while at least one source bit is set in its bitmap.

Each target CPU has its own acknowledge port. Choosing which ID to acknowledge is done outside this block. The CPU presents the ID it wants, and the block does three things:
- it picks the lowest-numbered source still requesting that ID;
- it clears that source's bit;
- it returns a response word that carries both the ID and the source number.

If several sources asked for the same ID, the ID stays pending until each of those sources has been acknowledged once. A separate byte-write port lets a CPU set or clear source bits directly in its own bitmaps.

All input ports are accepted in every cycle, so none of them has a ready signal and none applies back-pressure. A response appears as a one-cycle `rsp_valid` pulse in the cycle after the request. The receiver must take it in that cycle.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, all source bitmaps are empty, `pending` is all zero and `rsp_valid` is low.
- R2: A trigger word with filter bits [25:24] = 0 targets the CPUs listed in bits [23:16]. List bits at or above NUM_CPU are dropped. The ID is taken from bits [3:0].
- R3: A trigger word with filter = 1 targets every implemented CPU except the writer `trig_cpu`.
- R4: A trigger word with filter = 2 targets only the writer.
- R5: A trigger word with filter = 3 changes no state. A trigger with `trig_full_word` low also changes no state.
- R6: For each CPU targeted by an accepted trigger, the writer's bit is set in that CPU's bitmap for the ID. `pending[t*NUM_ID+i]` is high exactly while the bitmap for target t and ID i is non-empty. Pending changes one clock edge after the write.
- R7: An acknowledge request on port t for an ID with a non-empty bitmap clears the lowest set source bit. One cycle later the port returns `rsp_valid` with a word holding the ID in bits [9:0], that source in bits [12:10] and zeros elsewhere.
- R8: When several sources requested one ID, the ID stays pending on the target until the last source is acknowledged. Sources are served in ascending number order.
- R9: An acknowledge request for an ID whose bitmap is empty returns 0x3FF and changes nothing.
- R10: A byte write with `byte_clear` = 0 ORs `byte_data[NUM_CPU-1:0]` into the bitmap of ID `byte_id` on CPU `byte_cpu`. With `byte_clear` = 1 it removes those bits. In both cases pending follows the bitmap.
- R11: When an acknowledge and a trigger hit the same bitmap in the same cycle, two rules apply. The acknowledge chooses its source from the bitmap as it stood before the edge. Any bit set in that cycle is present after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger word write this cycle |
| trig_full_word | input | 1 | The trigger write is a full 32-bit access |
| trig_cpu | input | CPU_W | CPU number of the writer |
| trig_data | input | 32 | Trigger word |
| byte_valid | input | 1 | Byte write to a source bitmap this cycle |
| byte_clear | input | 1 | 1 = clear bits, 0 = set bits |
| byte_cpu | input | CPU_W | Writer CPU, which selects the bitmap bank |
| byte_id | input | ID_W | Software interrupt ID addressed |
| byte_data | input | 8 | Source bits to set or clear |
| ack_req | input | NUM_CPU | Acknowledge request, one bit per CPU |
| ack_id | input | NUM_CPU*ID_W | ID to acknowledge, one field per CPU |
| rsp_valid | output | NUM_CPU | Response strobe, one bit per CPU |
| rsp_word | output | NUM_CPU*32 | Response word, one field per CPU |
| pending | output | NUM_CPU*NUM_ID | Pending flag per target CPU and ID |

## Verification
An acknowledge and a new trigger can land on the same bitmap in the same clock cycle. The bench sets this up as follows:
- source 2 is made pending for ID 6 on CPU 1;
- in a single cycle, CPU 1 acknowledges ID 6 while CPU 0 triggers ID 6 at CPU 1.

The response must name source 2, the ID must still be pending afterwards, and a second acknowledge must then name source 0. Serving order when two sources share one ID is checked through the response fields and the moment pending drops.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int WORD_W  = 32;
  localparam int SRC_LSB = 10;
  localparam int SRC_W   = 3;
  localparam logic [WORD_W-1:0] SPURIOUS_WORD = 32'h0000_03FF;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_BAD    = 2'd3
  } sgi_filter_e;
endpackage

// File: rtl/sgi_trig_decode.sv
module sgi_trig_decode
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ID_W    = 4,
  parameter int CPU_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_valid,
  input  logic               trig_full_word,
  input  logic [CPU_W-1:0]   trig_cpu,
  input  logic [WORD_W-1:0]  trig_data,
  output logic               fire,
  output logic [NUM_CPU-1:0] tgt_mask,
  output logic [ID_W-1:0]    tgt_id
);
  sgi_filter_e        filter;
  logic [NUM_CPU-1:0] self_mask;

  always_comb begin
    filter    = sgi_filter_e'(trig_data[25:24]);
    self_mask = NUM_CPU'(1) << trig_cpu;
    tgt_id    = trig_data[ID_W-1:0];
    unique case (filter)
      FLT_LIST:   tgt_mask = trig_data[16 +: NUM_CPU];
      FLT_OTHERS: tgt_mask = ~self_mask;
      FLT_SELF:   tgt_mask = self_mask;
      default:    tgt_mask = '0;
    endcase
    fire = trig_valid && trig_full_word && (filter != FLT_BAD) && (tgt_mask != '0);
  end

  // R4: the self filter reaches exactly the writer
  a_r4_self_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && filter == FLT_SELF) |-> ($countones(tgt_mask) == 1 && tgt_mask[trig_cpu]));
  // R3: the others filter never reaches the writer
  a_r3_others_skip_writer: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && filter == FLT_OTHERS) |-> !tgt_mask[trig_cpu]);
endmodule

// File: rtl/sgi_src_cell.sv
module sgi_src_cell #(
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CPU-1:0] set_bits,
  input  logic [NUM_CPU-1:0] clr_bits,
  input  logic [NUM_CPU-1:0] ack_bits,
  output logic [NUM_CPU-1:0] bits,
  output logic               pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) bits <= '0;
    else        bits <= (bits & ~clr_bits & ~ack_bits) | set_bits;
  end

  assign pending = |bits;

  // R11: bits set in a cycle survive any clear in that cycle
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != '0) |=> ((bits & $past(set_bits)) == $past(set_bits)));
  // R8: with nothing removed, pending holds
  a_r8_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && (clr_bits | ack_bits) == '0) |=> pending);
  // R10: a cleared bit that is not set again is gone
  a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_bits & ~set_bits) != '0) |=> ((bits & $past(clr_bits & ~set_bits)) == '0));
endmodule

// File: rtl/sgi_ack_port.sv
module sgi_ack_port
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_ID  = 16,
  parameter int ID_W    = 4,
  parameter int CPU_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ack_req,
  input  logic [ID_W-1:0]           ack_id,
  input  logic [NUM_ID*NUM_CPU-1:0] bank,
  output logic [NUM_ID*NUM_CPU-1:0] ack_clr,
  output logic                      rsp_valid,
  output logic [WORD_W-1:0]         rsp_word
);
  logic [NUM_CPU-1:0] sel;
  logic [CPU_W-1:0]   src;
  logic [NUM_CPU-1:0] src_hot;
  logic               hit;
  logic [WORD_W-1:0]  word_d;
  logic [NUM_CPU-1:0] below_src;

  always_comb begin
    sel = bank[ack_id*NUM_CPU +: NUM_CPU];
    src = '0;
    for (int k = NUM_CPU - 1; k >= 0; k--) begin
      if (sel[k]) src = CPU_W'(k);
    end
    hit     = ack_req && (sel != '0);
    src_hot = hit ? (NUM_CPU'(1) << src) : '0;
    word_d  = '0;
    word_d[ID_W-1:0]          = ack_id;
    word_d[SRC_LSB +: SRC_W]  = SRC_W'(src);
    if (!hit) word_d = SPURIOUS_WORD;
  end

  for (genvar i = 0; i < NUM_ID; i++) begin : g_clr
    assign ack_clr[i*NUM_CPU +: NUM_CPU] = (ack_id == ID_W'(i)) ? src_hot : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_word  <= '0;
    end else begin
      rsp_valid <= ack_req;
      rsp_word  <= ack_req ? word_d : '0;
    end
  end

  always_comb below_src = (NUM_CPU'(1) << rsp_word[SRC_LSB +: SRC_W]) - NUM_CPU'(1);

  // R9: an empty bitmap answers with the spurious word
  a_r9_empty_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && sel == '0) |=> (rsp_valid && rsp_word == SPURIOUS_WORD));
  // R7: the served source is the lowest one requesting
  a_r7_lowest_source: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && sel != '0) |=> (($past(sel) & below_src) == '0));
  // R7: the response carries the requested ID
  a_r7_id_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && sel != '0) |=> (rsp_word[ID_W-1:0] == $past(ack_id)));
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_ID  = 16,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int ID_W   = $clog2(NUM_ID)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        trig_valid,
  input  logic                        trig_full_word,
  input  logic [CPU_W-1:0]            trig_cpu,
  input  logic [31:0]                 trig_data,
  input  logic                        byte_valid,
  input  logic                        byte_clear,
  input  logic [CPU_W-1:0]            byte_cpu,
  input  logic [ID_W-1:0]             byte_id,
  input  logic [7:0]                  byte_data,
  input  logic [NUM_CPU-1:0]          ack_req,
  input  logic [NUM_CPU*ID_W-1:0]     ack_id,
  output logic [NUM_CPU-1:0]          rsp_valid,
  output logic [NUM_CPU*32-1:0]       rsp_word,
  output logic [NUM_CPU*NUM_ID-1:0]   pending
);
  localparam int BANK_W = NUM_ID * NUM_CPU;

  logic               fire;
  logic [NUM_CPU-1:0] tgt_mask;
  logic [ID_W-1:0]    tgt_id;
  logic [NUM_CPU-1:0] writer_hot;

  assign writer_hot = NUM_CPU'(1) << trig_cpu;

  sgi_trig_decode #(.NUM_CPU(NUM_CPU), .ID_W(ID_W), .CPU_W(CPU_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_full_word(trig_full_word),
    .trig_cpu(trig_cpu), .trig_data(trig_data),
    .fire(fire), .tgt_mask(tgt_mask), .tgt_id(tgt_id)
  );

  for (genvar t = 0; t < NUM_CPU; t++) begin : g_tgt
    logic [BANK_W-1:0] bank;
    logic [BANK_W-1:0] ack_clr;
    logic              bank_sel;

    assign bank_sel = byte_valid && (byte_cpu == CPU_W'(t));

    for (genvar i = 0; i < NUM_ID; i++) begin : g_id
      logic [NUM_CPU-1:0] set_bits;
      logic [NUM_CPU-1:0] clr_bits;
      logic               id_byte;

      always_comb begin
        id_byte  = bank_sel && (byte_id == ID_W'(i));
        set_bits = '0;
        clr_bits = '0;
        if (fire && tgt_mask[t] && tgt_id == ID_W'(i)) set_bits = writer_hot;
        if (id_byte && !byte_clear) set_bits = set_bits | byte_data[NUM_CPU-1:0];
        if (id_byte &&  byte_clear) clr_bits = byte_data[NUM_CPU-1:0];
      end

      sgi_src_cell #(.NUM_CPU(NUM_CPU)) u_cell (
        .clk(clk), .rst_n(rst_n),
        .set_bits(set_bits), .clr_bits(clr_bits),
        .ack_bits(ack_clr[i*NUM_CPU +: NUM_CPU]),
        .bits(bank[i*NUM_CPU +: NUM_CPU]),
        .pending(pending[t*NUM_ID + i])
      );
    end

    sgi_ack_port #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID), .ID_W(ID_W), .CPU_W(CPU_W)) u_ack (
      .clk(clk), .rst_n(rst_n),
      .ack_req(ack_req[t]), .ack_id(ack_id[t*ID_W +: ID_W]),
      .bank(bank), .ack_clr(ack_clr),
      .rsp_valid(rsp_valid[t]), .rsp_word(rsp_word[t*32 +: 32])
    );
  end

  // R5: a bad-filter trigger alone leaves all pending state unchanged
  a_r5_bad_filter_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_data[25:24] == 2'b11 && !byte_valid && ack_req == '0) |=> $stable(pending));
  // R5: a partial-width trigger alone leaves pending unchanged
  a_r5_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && !trig_full_word && !byte_valid && ack_req == '0) |=> $stable(pending));
endmodule

// File: tb/sgi_dispatch_test.sv
module sgi_dispatch_test;
  localparam int CLK_P   = 10;
  localparam int NUM_CPU = 4;
  localparam int NUM_ID  = 16;
  localparam int CPU_W   = 2;
  localparam int ID_W    = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic trig_valid, trig_full_word;
  logic [CPU_W-1:0] trig_cpu;
  logic [31:0] trig_data;
  logic byte_valid, byte_clear;
  logic [CPU_W-1:0] byte_cpu;
  logic [ID_W-1:0] byte_id;
  logic [7:0] byte_data;
  logic [NUM_CPU-1:0] ack_req;
  logic [NUM_CPU*ID_W-1:0] ack_id;
  logic [NUM_CPU-1:0] rsp_valid;
  logic [NUM_CPU*32-1:0] rsp_word;
  logic [NUM_CPU*NUM_ID-1:0] pending;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  sgi_dispatch #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) uut (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_full_word(trig_full_word),
    .trig_cpu(trig_cpu), .trig_data(trig_data),
    .byte_valid(byte_valid), .byte_clear(byte_clear),
    .byte_cpu(byte_cpu), .byte_id(byte_id), .byte_data(byte_data),
    .ack_req(ack_req), .ack_id(ack_id),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .pending(pending)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [NUM_ID-1:0] pend_of(int t);
    return pending[t*NUM_ID +: NUM_ID];
  endfunction

  task automatic idle_inputs();
    trig_valid = 0; trig_full_word = 0; trig_cpu = '0; trig_data = '0;
    byte_valid = 0; byte_clear = 0; byte_cpu = '0; byte_id = '0; byte_data = '0;
    ack_req = '0; ack_id = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic trig(int cpu, logic [31:0] data, logic full);
    trig_valid = 1; trig_full_word = full; trig_cpu = CPU_W'(cpu); trig_data = data;
    @(negedge clk);
    trig_valid = 0; trig_full_word = 0;
  endtask

  task automatic byte_wr(logic clr, int cpu, int id, logic [7:0] data);
    byte_valid = 1; byte_clear = clr; byte_cpu = CPU_W'(cpu);
    byte_id = ID_W'(id); byte_data = data;
    @(negedge clk);
    byte_valid = 0;
  endtask

  task automatic ack(int t, int id, output logic [31:0] word);
    ack_req[t] = 1'b1;
    ack_id[t*ID_W +: ID_W] = ID_W'(id);
    @(negedge clk);
    ack_req[t] = 1'b0;
    chk("R7 rsp_valid", 32'(rsp_valid[t]), 32'd1);
    word = rsp_word[t*32 +: 32];
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pending", 32'(pending), 32'd0);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_list();
    logic [31:0] w;
    do_reset();
    // R2: writer 1, list 0xF5 (only bits 0 and 2 implemented), ID 5
    trig(1, 32'h00F5_0005, 1'b1);
    chk("R2 cpu0", 32'(pend_of(0)), 32'h0020);
    chk("R2 cpu1", 32'(pend_of(1)), 32'h0000);
    chk("R2 cpu2", 32'(pend_of(2)), 32'h0020);
    chk("R2 cpu3", 32'(pend_of(3)), 32'h0000);
    ack(2, 5, w);
    chk("R7 word list", w, 32'h0000_0405);
    chk("R6 cleared", 32'(pend_of(2)), 32'h0000);
  endtask

  task automatic t_others_self();
    do_reset();
    trig(2, 32'h0100_0007, 1'b1);  // R3
    chk("R3 cpu0", 32'(pend_of(0)), 32'h0080);
    chk("R3 cpu1", 32'(pend_of(1)), 32'h0080);
    chk("R3 cpu2", 32'(pend_of(2)), 32'h0000);
    chk("R3 cpu3", 32'(pend_of(3)), 32'h0080);
    do_reset();
    trig(3, 32'h020F_0009, 1'b1);  // R4
    chk("R4 cpu3", 32'(pend_of(3)), 32'h0200);
    chk("R4 others", 32'(pend_of(0) | pend_of(1) | pend_of(2)), 32'h0000);
  endtask

  task automatic t_ignored();
    logic [31:0] w;
    do_reset();
    trig(0, 32'h030F_0003, 1'b1);  // R5 bad filter
    chk("R5 bad filter", 32'(pending), 32'd0);
    trig(0, 32'h000F_0003, 1'b0);  // R5 partial write
    chk("R5 partial", 32'(pending), 32'd0);
    ack(1, 3, w);
    chk("R9 empty ack", w, 32'h0000_03FF);
  endtask

  task automatic t_two_sources();
    logic [31:0] w;
    do_reset();
    trig(3, 32'h0001_0004, 1'b1);
    trig(1, 32'h0001_0004, 1'b1);
    chk("R6 pend two", 32'(pend_of(0)), 32'h0010);
    ack(0, 4, w);
    chk("R8 first src1", w, 32'h0000_0404);
    chk("R8 still pend", 32'(pend_of(0)), 32'h0010);
    ack(0, 4, w);
    chk("R8 second src3", w, 32'h0000_0C04);
    chk("R8 pend drops", 32'(pend_of(0)), 32'h0000);
    ack(0, 4, w);
    chk("R9 after drain", w, 32'h0000_03FF);
  endtask

  task automatic t_bytes();
    logic [31:0] w;
    do_reset();
    byte_wr(1'b0, 2, 11, 8'h06);
    chk("R10 set byte", 32'(pend_of(2)), 32'h0800);
    ack(2, 11, w);
    chk("R10 src1", w, 32'h0000_040B);
    byte_wr(1'b1, 2, 11, 8'h04);
    chk("R10 clear byte", 32'(pend_of(2)), 32'h0000);
  endtask

  task automatic t_same_cycle();
    logic [31:0] w;
    do_reset();
    trig(2, 32'h0002_0006, 1'b1);
    // R11: ack and new trigger in one cycle
    ack_req[1] = 1'b1;
    ack_id[1*ID_W +: ID_W] = 4'd6;
    trig_valid = 1; trig_full_word = 1; trig_cpu = 2'd0; trig_data = 32'h0002_0006;
    @(negedge clk);
    ack_req[1] = 1'b0; trig_valid = 0; trig_full_word = 0;
    chk("R11 src2 served", rsp_word[32 +: 32], 32'h0000_0806);
    chk("R11 still pend", 32'(pend_of(1)), 32'h0040);
    ack(1, 6, w);
    chk("R11 src0 next", w, 32'h0000_0006);
    chk("R11 pend drops", 32'(pend_of(1)), 32'h0000);
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    t_reset();
    t_list();
    t_others_self();
    t_ignored();
    t_two_sources();
    t_bytes();
    t_same_cycle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule